// File: doc/BRIEF.md
# Multi-Lane Serial Integer Divider

This block divides several 32-bit lanes at once under a single request. A request carries one dividend and one divisor per lane, a mode bit that selects signed (two's-complement) or unsigned division, and an opaque tag. The unit accepts the request through a valid/ready handshake. It then computes the quotient and remainder of every lane in parallel. Each lane uses a shift-subtract datapath that produces one quotient bit per clock. This trades latency for a small datapath.

When all lanes are done, the unit presents the results and the tag behind its own valid/ready pair. A downstream arbiter can stall the results for as long as it needs. The unit takes no new request until the current results have been taken. Division by zero and the one signed overflow case give fixed results and raise no exception.

Top module: `lane_serial_divider`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `valid_out` is low and `ready_in` is high. Asserting reset during a computation discards that computation, and no result is ever presented for it.
- R2: A request is accepted on a rising edge where `valid_in` and `ready_in` are both high. From the next cycle, `ready_in` stays low until the results have been taken.
- R3: `valid_out` rises exactly WIDTH+2 (34) rising edges after the acceptance edge: one edge for setup, WIDTH edges for iterations and one edge for the sign fix-up.
- R4: With `signed_mode` low, each lane returns the unsigned quotient and remainder of its operands.
- R5: With `signed_mode` high, each lane's quotient is truncated toward zero, and a nonzero remainder has the sign of the dividend.
- R6: A lane whose divisor is zero returns quotient 0xFFFFFFFF and a remainder equal to its dividend, in both modes.
- R7: In signed mode, 0x80000000 divided by 0xFFFFFFFF (-1) returns quotient 0x80000000 and remainder 0.
- R8: `tag_out` shows the `tag_in` value captured at acceptance, for as long as `valid_out` is high.
- R9: While `valid_out` is high and `ready_out` is low, `valid_out`, `quotient`, `remainder` and `tag_out` hold their values. On the edge where both are high the results are consumed: in the next cycle `valid_out` is low and `ready_in` is high.
- R10: Lane i of `quotient`/`remainder` (bits [32*i+31:32*i]) depends only on lane i of `numer`/`denom`.
- R11: Changes to `numer`, `denom`, `signed_mode`, `tag_in` and `valid_in` while a request is in progress have no effect on that request's results or tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Request present |
| ready_in | output | 1 | Unit idle, can accept a request |
| signed_mode | input | 1 | 1 = signed division, 0 = unsigned |
| tag_in | input | TAG_W | Opaque tag for the request |
| numer | input | LANES*WIDTH | Dividend per lane |
| denom | input | LANES*WIDTH | Divisor per lane |
| valid_out | output | 1 | Results present |
| ready_out | input | 1 | Consumer takes the results |
| quotient | output | LANES*WIDTH | Quotient per lane |
| remainder | output | LANES*WIDTH | Remainder per lane |
| tag_out | output | TAG_W | Tag of the presented request |

## Verification
The bench drives each request at a falling edge. It then counts falling edges until `valid_out` appears and requires exactly 34 of them after the acceptance edge. Quotient, remainder and tag are compared at that first valid sample. They are compared again after three stalled cycles with `ready_out` low. After `ready_out` is raised for one edge, the bench expects `valid_out` low and `ready_in` high at the next falling edge. The reset test asserts reset ten cycles into a computation and checks the idle state one cycle later. It then watches 40 further cycles for a result that must never appear.

// File: rtl/lane_serial_divider.sv
module lane_serial_divider #(
  parameter int LANES = 2,
  parameter int WIDTH = 32,
  parameter int TAG_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         valid_in,
  output logic                         ready_in,
  input  logic                         signed_mode,
  input  logic [TAG_W-1:0]             tag_in,
  input  logic [LANES-1:0][WIDTH-1:0]  numer,
  input  logic [LANES-1:0][WIDTH-1:0]  denom,
  output logic                         valid_out,
  input  logic                         ready_out,
  output logic [LANES-1:0][WIDTH-1:0]  quotient,
  output logic [LANES-1:0][WIDTH-1:0]  remainder,
  output logic [TAG_W-1:0]             tag_out
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_FIX, S_DONE} state_t;

  state_t             state;
  logic [CNT_W-1:0]   iter;
  logic               mode_r;
  logic [TAG_W-1:0]   tag_r;

  wire accept = valid_in && ready_in;

  assign ready_in  = (state == S_IDLE);
  assign valid_out = (state == S_DONE);
  assign tag_out   = tag_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      iter  <= '0;
    end else begin
      case (state)
        S_IDLE:  if (accept) state <= S_SETUP;
        S_SETUP: begin
          state <= S_RUN;
          iter  <= '0;
        end
        S_RUN: begin
          iter <= iter + 1'b1;
          if (iter == LAST_ITER) state <= S_FIX;
        end
        S_FIX:   state <= S_DONE;
        S_DONE:  if (ready_out) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      mode_r <= signed_mode;
      tag_r  <= tag_in;
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WIDTH-1:0] num_r, den_r, dmag_r, quo_r, q_res, r_res;
    logic [WIDTH:0]   rem_r;

    wire             n_neg   = mode_r & num_r[WIDTH-1];
    wire             d_neg   = mode_r & den_r[WIDTH-1];
    wire [WIDTH-1:0] n_mag   = n_neg ? (~num_r + 1'b1) : num_r;
    wire [WIDTH-1:0] d_mag   = d_neg ? (~den_r + 1'b1) : den_r;
    wire [WIDTH:0]   shifted = {rem_r[WIDTH-1:0], quo_r[WIDTH-1]};
    wire [WIDTH:0]   trial   = shifted - {1'b0, dmag_r};
    wire             by_zero = (den_r == '0);
    wire [WIDTH-1:0] rem_lo  = rem_r[WIDTH-1:0];

    always_ff @(posedge clk) begin
      if (accept) begin
        num_r <= numer[i];
        den_r <= denom[i];
      end
      case (state)
        S_SETUP: begin
          dmag_r <= d_mag;
          quo_r  <= n_mag;
          rem_r  <= '0;
        end
        S_RUN: begin
          if (!trial[WIDTH]) begin
            rem_r <= trial;
            quo_r <= {quo_r[WIDTH-2:0], 1'b1};
          end else begin
            rem_r <= shifted;
            quo_r <= {quo_r[WIDTH-2:0], 1'b0};
          end
        end
        S_FIX: begin
          q_res <= by_zero ? '1 : ((n_neg ^ d_neg) ? (~quo_r + 1'b1) : quo_r);
          r_res <= by_zero ? num_r : (n_neg ? (~rem_lo + 1'b1) : rem_lo);
        end
        default: ;
      endcase
    end

    assign quotient[i]  = q_res;
    assign remainder[i] = r_res;

    AST_DZ_RESULT: assert property (@(posedge clk) disable iff (rst)
      (valid_out && den_r == '0) |-> (quotient[i] == '1 && remainder[i] == num_r)); // R6
    AST_UREM_BOUND: assert property (@(posedge clk) disable iff (rst)
      (valid_out && !mode_r && den_r != '0) |-> (remainder[i] < den_r)); // R4
  end

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!valid_out && ready_in)); // R1
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (valid_in && ready_in) |=> !ready_in); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !ready_out) |=> (valid_out && $stable(quotient) && $stable(remainder))); // R9
  AST_TAG_STABLE: assert property (@(posedge clk) disable iff (rst)
    (valid_out && !ready_out) |=> $stable(tag_out)); // R8
  AST_CONSUME_FREES: assert property (@(posedge clk) disable iff (rst)
    (valid_out && ready_out) |=> (ready_in && !valid_out)); // R9
endmodule

// File: tb/lane_serial_divider_tb_top.sv
module lane_serial_divider_tb_top;
  localparam int LANES = 2;
  localparam int W = 32;
  localparam int TAG_W = 4;
  localparam int NVEC = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, valid_in, ready_in, signed_mode, valid_out, ready_out;
  logic [TAG_W-1:0] tag_in, tag_out;
  logic [LANES-1:0][W-1:0] numer, denom, quotient, remainder;

  int checks = 0;
  int errors = 0;

  lane_serial_divider #(.LANES(LANES), .WIDTH(W), .TAG_W(TAG_W)) dut_i (
    .clk(clk), .rst(rst), .valid_in(valid_in), .ready_in(ready_in),
    .signed_mode(signed_mode), .tag_in(tag_in), .numer(numer), .denom(denom),
    .valid_out(valid_out), .ready_out(ready_out), .quotient(quotient),
    .remainder(remainder), .tag_out(tag_out)
  );

  // {mode, n0, d0, n1, d1}
  localparam logic [128:0] VEC [NVEC] = '{
    {1'b0, 32'd100,        32'd7,        32'hFFFFFFFF, 32'd3},         // R4 R10
    {1'b1, 32'hFFFFFF9C,   32'd7,        32'd100,      32'hFFFFFFF9},  // R5
    {1'b1, 32'hFFFFFF9C,   32'hFFFFFFF9, 32'd0,        32'd5},         // R5
    {1'b0, 32'd12345,      32'd0,        32'h80000000, 32'hFFFFFFFF},  // R6 R4
    {1'b1, 32'h80000000,   32'hFFFFFFFF, 32'hFFFFFFF6, 32'd0},         // R7 R6
    {1'b0, 32'hDEADBEEF,   32'h10,       32'd5,        32'd9},         // R4
    {1'b1, 32'h7FFFFFFF,   32'h80000000, 32'h80000000, 32'd2},         // R5
    {1'b0, 32'd1,          32'd1,        32'hFFFFFFFF, 32'hFFFFFFFF}   // R4
  };

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic m, input logic [W-1:0] n, input logic [W-1:0] d);
    if (d == 0) return "R6";
    if (m && n == 32'h80000000 && d == 32'hFFFFFFFF) return "R7";
    return m ? "R5" : "R4";
  endfunction

  function automatic logic [2*W-1:0] ref_div(input logic m, input logic [W-1:0] n, input logic [W-1:0] d);
    if (d == 0) return {32'hFFFFFFFF, n};
    if (m && n == 32'h80000000 && d == 32'hFFFFFFFF) return {n, 32'd0};
    if (m) return {W'($signed(n) / $signed(d)), W'($signed(n) % $signed(d))};
    return {n / d, n % d};
  endfunction

  task automatic run_req(input logic m, input logic [LANES-1:0][W-1:0] n,
                         input logic [LANES-1:0][W-1:0] d, input logic [TAG_W-1:0] t,
                         input bit disturb);
    int lat;
    logic [LANES-1:0][W-1:0] q0, r0;
    logic [TAG_W-1:0] t0;
    @(negedge clk);
    signed_mode = m; numer = n; denom = d; tag_in = t; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
    lat = 0;
    chk("R2 ready_in low after accept", W'(ready_in), 0);
    while (!valid_out && lat < 100) begin
      @(negedge clk);
      lat++;
      if (disturb && lat == 5) begin
        numer = ~n; denom = ~d; tag_in = ~t; signed_mode = ~m; valid_in = 1'b1;
      end
      if (disturb && lat == 7) valid_in = 1'b0;
    end
    chk("R3 latency", W'(lat), W'(W + 2));
    chk("R2 ready_in low while valid", W'(ready_in), 0);
    chk(disturb ? "R11 tag" : "R8 tag", W'(tag_out), W'(t));
    for (int l = 0; l < LANES; l++) begin
      logic [2*W-1:0] e = ref_div(m, n[l], d[l]);
      string rq = disturb ? "R11" : req_of(m, n[l], d[l]);
      chk({rq, " R10 quotient"}, quotient[l], e[2*W-1:W]);
      chk({rq, " R10 remainder"}, remainder[l], e[W-1:0]);
    end
    q0 = quotient; r0 = remainder; t0 = tag_out;
    repeat (3) @(negedge clk);
    chk("R9 valid held", W'(valid_out), 1);
    chk("R9 tag held", W'(tag_out), W'(t0));
    for (int l = 0; l < LANES; l++) begin
      chk("R9 quotient held", quotient[l], q0[l]);
      chk("R9 remainder held", remainder[l], r0[l]);
    end
    ready_out = 1'b1;
    @(negedge clk);
    ready_out = 1'b0;
    chk("R9 valid_out dropped", W'(valid_out), 0);
    chk("R9 ready_in back", W'(ready_in), 1);
  endtask

  initial begin
    rst = 1'b1; valid_in = 1'b0; ready_out = 1'b0; signed_mode = 1'b0;
    tag_in = '0; numer = '0; denom = '0;
    repeat (3) @(negedge clk);
    chk("R1 ready_in in reset", W'(ready_in), 1);
    chk("R1 valid_out in reset", W'(valid_out), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ready_in after reset", W'(ready_in), 1);

    for (int i = 0; i < NVEC; i++) begin
      logic [128:0] v = VEC[i];
      logic [LANES-1:0][W-1:0] n, d;
      n[0] = v[127:96]; d[0] = v[95:64]; n[1] = v[63:32]; d[1] = v[31:0];
      run_req(v[128], n, d, TAG_W'(i + 3), 1'b0);
    end

    begin : r11_test
      logic [LANES-1:0][W-1:0] n, d;
      n[0] = 32'hFFFFF000; d[0] = 32'd48; n[1] = 32'd77; d[1] = 32'hFFFFFFFE;
      run_req(1'b1, n, d, 4'hA, 1'b1);
    end

    begin : r1_abort
      int seen;
      @(negedge clk);
      signed_mode = 1'b0; numer = '1; denom = '1; tag_in = 4'h5; valid_in = 1'b1;
      @(negedge clk);
      valid_in = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk("R1 abort ready_in", W'(ready_in), 1);
      chk("R1 abort valid_out", W'(valid_out), 0);
      seen = 0;
      repeat (40) begin
        @(negedge clk);
        if (valid_out) seen++;
      end
      chk("R1 no result after abort", W'(seen), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule